// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative cache of page translations. Every slot holds a virtual page number, a physical page number, an address space number, a global bit that lets the slot serve every address space, per-mode read and write enable bits, fault-on-read and fault-on-write flags, and a valid bit. A client presents a virtual page number and the current address space number. In the same cycle it receives a hit flag, the index of the slot that hit, and that slot's fields. Permission checks and page walks belong to the client.

New translations are written through an insert port. Slots are chosen by a rotating victim pointer, so the oldest insert is the first to be overwritten. Three invalidation commands are provided. One clears everything. One drops every slot that is not global, which is used on an address space switch. One drops the slots that match a single virtual address in a given address space.

Top module: `asn_tlb`

## Requirements
- R1: After reset every slot is invalid, every lookup misses with all result fields zero, and the first insert lands in slot 0.
- R2: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global bit is set or whose stored ASN equals `lk_asn`. A slot that fails either test does not hit.
- R3: The lookup result is combinational. On a hit it returns the slot index, PPN, global bit, read enables, write enables and the two fault flags of the matching slot. On a miss all of these are zero.
- R4: When more than one slot matches, the slot with the lowest index is reported.
- R5: An insert writes the slot named by the victim pointer. The tag is `ins_vaddr[VA_W-1:PG_BITS]`, the other fields come from the `ins_*` inputs, and the slot becomes valid on the next clock edge.
- R6: The victim pointer advances by one on each insert and wraps from ENTRIES-1 to 0. A valid slot at the pointer is overwritten, so its old translation stops hitting.
- R7: `flush_all` invalidates every slot, clears every field and returns the victim pointer to 0. An insert in the same cycle is discarded.
- R8: `flush_proc` invalidates every slot whose global bit is clear. Global slots keep hitting.
- R9: `flush_addr` invalidates exactly the valid slots whose tag equals `fl_vaddr[VA_W-1:PG_BITS]` and that pass the global-or-ASN test against `fl_asn`. All other slots are unaffected.
- R10: When an insert and `flush_proc` or `flush_addr` occur in the same cycle, the invalidation uses the slot contents from before the edge, and the newly inserted slot is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VA_W-PG_BITS | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | $clog2(ENTRIES) | Index of the hitting slot |
| lk_ppn | output | PPN_W | Physical page number |
| lk_glb | output | 1 | Global bit of the hitting slot |
| lk_rd_en | output | MODES | Per-mode read enables |
| lk_wr_en | output | MODES | Per-mode write enables |
| lk_flt_rd | output | 1 | Fault-on-read flag |
| lk_flt_wr | output | 1 | Fault-on-write flag |
| ins_en | input | 1 | Insert strobe |
| ins_vaddr | input | VA_W | Virtual address of the new translation |
| ins_ppn | input | PPN_W | New physical page number |
| ins_asn | input | ASN_W | New address space number |
| ins_glb | input | 1 | New global bit |
| ins_rd_en | input | MODES | New read enables |
| ins_wr_en | input | MODES | New write enables |
| ins_flt_rd | input | 1 | New fault-on-read flag |
| ins_flt_wr | input | 1 | New fault-on-write flag |
| flush_all | input | 1 | Invalidate everything |
| flush_proc | input | 1 | Invalidate all non-global slots |
| flush_addr | input | 1 | Invalidate by address and ASN |
| fl_vaddr | input | VA_W | Virtual address for flush_addr |
| fl_asn | input | ASN_W | ASN for flush_addr |

## Verification
The hardest situation to reach is a buffer that holds several slots with the same tag across different address spaces, some of them global, while the victim pointer has already wrapped. Only in that state do priority, selective flushes and eviction interact. The stimulus draws tags and ASNs from very small pools and runs a small instance long enough to wrap many times. It also mixes inserts with same-cycle flushes. Directed sequences cover duplicate global entries, a flush by address that hits the slot being replaced, and an insert that coincides with a full flush.

// File: rtl/asn_tlb.sv
module asn_tlb #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 43,
  parameter int PG_BITS = 13,
  parameter int PPN_W   = 27,
  parameter int ASN_W   = 8,
  parameter int MODES   = 4,
  localparam int VPN_W  = VA_W - PG_BITS,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_glb,
  output logic [MODES-1:0] lk_rd_en,
  output logic [MODES-1:0] lk_wr_en,
  output logic             lk_flt_rd,
  output logic             lk_flt_wr,
  input  logic             ins_en,
  input  logic [VA_W-1:0]  ins_vaddr,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_glb,
  input  logic [MODES-1:0] ins_rd_en,
  input  logic [MODES-1:0] ins_wr_en,
  input  logic             ins_flt_rd,
  input  logic             ins_flt_wr,
  input  logic             flush_all,
  input  logic             flush_proc,
  input  logic             flush_addr,
  input  logic [VA_W-1:0]  fl_vaddr,
  input  logic [ASN_W-1:0] fl_asn
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [ASN_W-1:0] asn_q [ENTRIES];
  logic [MODES-1:0] rde_q [ENTRIES];
  logic [MODES-1:0] wre_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, glb_q, frd_q, fwr_q;
  logic [IDX_W-1:0] ptr_q;

  logic [ENTRIES-1:0] lk_m, fl_m;
  logic [IDX_W-1:0]   sel;
  wire  [VPN_W-1:0]   fl_vpn  = fl_vaddr[VA_W-1:PG_BITS];
  wire  [VPN_W-1:0]   ins_vpn = ins_vaddr[VA_W-1:PG_BITS];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      lk_m[i] = vld_q[i] && tag_q[i] == lk_vpn && (glb_q[i] || asn_q[i] == lk_asn);
      fl_m[i] = vld_q[i] && tag_q[i] == fl_vpn && (glb_q[i] || asn_q[i] == fl_asn);
    end
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (lk_m[i]) sel = IDX_W'(i);
  end

  assign lk_hit    = |lk_m;
  assign lk_idx    = lk_hit ? sel : '0;
  assign lk_ppn    = lk_hit ? ppn_q[sel] : '0;
  assign lk_glb    = lk_hit & glb_q[sel];
  assign lk_rd_en  = lk_hit ? rde_q[sel] : '0;
  assign lk_wr_en  = lk_hit ? wre_q[sel] : '0;
  assign lk_flt_rd = lk_hit & frd_q[sel];
  assign lk_flt_wr = lk_hit & fwr_q[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ppn_q[i] <= '0;
        asn_q[i] <= '0;
        rde_q[i] <= '0;
        wre_q[i] <= '0;
      end
      vld_q <= '0;
      glb_q <= '0;
      frd_q <= '0;
      fwr_q <= '0;
      ptr_q <= '0;
    end else if (flush_all) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ppn_q[i] <= '0;
        asn_q[i] <= '0;
        rde_q[i] <= '0;
        wre_q[i] <= '0;
      end
      vld_q <= '0;
      glb_q <= '0;
      frd_q <= '0;
      fwr_q <= '0;
      ptr_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if ((flush_proc && !glb_q[i]) || (flush_addr && fl_m[i]))
          vld_q[i] <= 1'b0;
      if (ins_en) begin
        tag_q[ptr_q] <= ins_vpn;
        ppn_q[ptr_q] <= ins_ppn;
        asn_q[ptr_q] <= ins_asn;
        rde_q[ptr_q] <= ins_rd_en;
        wre_q[ptr_q] <= ins_wr_en;
        glb_q[ptr_q] <= ins_glb;
        frd_q[ptr_q] <= ins_flt_rd;
        fwr_q[ptr_q] <= ins_flt_wr;
        vld_q[ptr_q] <= 1'b1;
        ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  // R7
  flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld_q == '0 && ptr_q == '0));

  // R5
  ins_lands_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !flush_all) |=> (vld_q[$past(ptr_q)] && tag_q[$past(ptr_q)] == $past(ins_vpn)));

  // R6
  ptr_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_en && !flush_all) |=> $stable(ptr_q));

  // R8
  flush_proc_keeps_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_proc && !flush_all && !ins_en) |=> ((vld_q & ~glb_q) == '0));

  // R2
  hit_is_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (vld_q[lk_idx] && tag_q[lk_idx] == lk_vpn && (glb_q[lk_idx] || asn_q[lk_idx] == lk_asn)));

endmodule

// File: tb/asn_tlb_tb_top.sv
module asn_tlb_tb_top;
  localparam int N = 8, VA = 20, PG = 8, PPN = 12, ASN = 4, MD = 4;
  localparam int VPN = VA - PG, IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [VPN-1:0] lk_vpn = '0;
  logic [ASN-1:0] lk_asn = '0;
  logic lk_hit, lk_glb, lk_flt_rd, lk_flt_wr;
  logic [IW-1:0] lk_idx;
  logic [PPN-1:0] lk_ppn;
  logic [MD-1:0] lk_rd_en, lk_wr_en;
  logic ins_en = 0, ins_glb = 0, ins_flt_rd = 0, ins_flt_wr = 0;
  logic [VA-1:0] ins_vaddr = '0, fl_vaddr = '0;
  logic [PPN-1:0] ins_ppn = '0;
  logic [ASN-1:0] ins_asn = '0, fl_asn = '0;
  logic [MD-1:0] ins_rd_en = '0, ins_wr_en = '0;
  logic flush_all = 0, flush_proc = 0, flush_addr = 0;

  asn_tlb #(.ENTRIES(N), .VA_W(VA), .PG_BITS(PG), .PPN_W(PPN), .ASN_W(ASN), .MODES(MD)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_ppn(lk_ppn), .lk_glb(lk_glb), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
    .lk_flt_rd(lk_flt_rd), .lk_flt_wr(lk_flt_wr), .ins_en(ins_en), .ins_vaddr(ins_vaddr),
    .ins_ppn(ins_ppn), .ins_asn(ins_asn), .ins_glb(ins_glb), .ins_rd_en(ins_rd_en),
    .ins_wr_en(ins_wr_en), .ins_flt_rd(ins_flt_rd), .ins_flt_wr(ins_flt_wr),
    .flush_all(flush_all), .flush_proc(flush_proc), .flush_addr(flush_addr),
    .fl_vaddr(fl_vaddr), .fl_asn(fl_asn));

  int checks = 0, failures = 0;

  logic [VPN-1:0] m_tag [N];
  logic [PPN-1:0] m_ppn [N];
  logic [ASN-1:0] m_asn [N];
  logic [MD-1:0]  m_rd [N], m_wr [N];
  logic m_v [N], m_g [N], m_fr [N], m_fw [N];
  int m_ptr;

  localparam int RW = 1 + IW + PPN + 1 + 2*MD + 2;

  function automatic logic [RW-1:0] expect_lk(logic [VPN-1:0] v, logic [ASN-1:0] a);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_tag[i] == v && (m_g[i] || m_asn[i] == a))
        return {1'b1, IW'(i), m_ppn[i], m_g[i], m_rd[i], m_wr[i], m_fr[i], m_fw[i]};
    return '0;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_fr[i] = 0; m_fw[i] = 0;
      m_tag[i] = '0; m_ppn[i] = '0; m_asn[i] = '0; m_rd[i] = '0; m_wr[i] = '0;
    end
    m_ptr = 0;
  endtask

  task automatic model_step();
    logic kill [N];
    if (flush_all) begin
      model_clear();
      return;
    end
    for (int i = 0; i < N; i++)
      kill[i] = (flush_proc && !m_g[i]) ||
                (flush_addr && m_v[i] && m_tag[i] == fl_vaddr[VA-1:PG] && (m_g[i] || m_asn[i] == fl_asn));
    for (int i = 0; i < N; i++) if (kill[i]) m_v[i] = 0;
    if (ins_en) begin
      m_tag[m_ptr] = ins_vaddr[VA-1:PG]; m_ppn[m_ptr] = ins_ppn; m_asn[m_ptr] = ins_asn;
      m_g[m_ptr] = ins_glb; m_rd[m_ptr] = ins_rd_en; m_wr[m_ptr] = ins_wr_en;
      m_fr[m_ptr] = ins_flt_rd; m_fw[m_ptr] = ins_flt_wr; m_v[m_ptr] = 1;
      m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    ins_en = 0; flush_all = 0; flush_proc = 0; flush_addr = 0;
  endtask

  task automatic set_ins(int vpn, int ppn, int asn, bit g);
    ins_en = 1;
    ins_vaddr = {VPN'(vpn), PG'($urandom)};
    ins_ppn = PPN'(ppn); ins_asn = ASN'(asn); ins_glb = g;
    ins_rd_en = MD'($urandom); ins_wr_en = MD'($urandom);
    ins_flt_rd = 1'($urandom); ins_flt_wr = 1'($urandom);
  endtask

  task automatic set_fla(int vpn, int asn);
    flush_addr = 1; fl_vaddr = {VPN'(vpn), PG'($urandom)}; fl_asn = ASN'(asn);
  endtask

  task automatic chk(int vpn, int asn, string req);
    logic [RW-1:0] exp_v, act;
    lk_vpn = VPN'(vpn); lk_asn = ASN'(asn);
    #1;
    exp_v = expect_lk(lk_vpn, lk_asn);
    act = {lk_hit, lk_idx, lk_ppn, lk_glb, lk_rd_en, lk_wr_en, lk_flt_rd, lk_flt_wr};
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s vpn=%0d asn=%0d actual=%h expected=%h", req, vpn, asn, act, exp_v);
    end
  endtask

  task automatic chk_bit(logic act, logic exp_v, string req);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp_v);
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    model_clear();
    repeat (3) @(negedge clk);
    // R1: lookups miss in reset and right after
    chk(0, 0, "R1");
    rst_n = 1;
    @(negedge clk);
    for (int v = 0; v < 4; v++) chk(v, v, "R1");
    set_ins(3, 11, 2, 0); cyc();
    chk(3, 2, "R1");
    chk_bit(lk_idx == 0, 1'b1, "R1 first insert at slot 0");
    // R2: asn mismatch misses, global matches any asn
    chk(3, 5, "R2");
    set_ins(4, 22, 1, 1); cyc();
    chk(4, 9, "R2");
    chk_bit(lk_hit, 1'b1, "R2 global hit");
    // R4: duplicate global tags, lowest wins
    set_ins(4, 33, 7, 1); cyc();
    chk(4, 3, "R4");
    chk_bit(lk_idx == 1, 1'b1, "R4 lowest index");
    // R3: combinational lookup, fields change same cycle as inputs
    chk(3, 2, "R3");
    // R6: wrap; fill past N, slot 0 evicted
    for (int k = 0; k < N - 3; k++) begin set_ins(8 + k, 40 + k, 1, 0); cyc(); end
    set_ins(15, 99, 1, 0); cyc();
    chk(3, 2, "R6 evicted");
    chk(15, 1, "R6");
    chk_bit(lk_idx == 0, 1'b1, "R6 wrap to slot 0");
    // R9: flush by address, only matching slot
    set_fla(8, 1); cyc();
    chk(8, 1, "R9");
    chk(9, 1, "R9");
    chk(4, 0, "R9");
    // R8: flush_proc keeps globals
    flush_proc = 1; cyc();
    chk(4, 6, "R8");
    chk_bit(lk_hit, 1'b1, "R8 global survives");
    chk(9, 1, "R8");
    // R10: insert plus flush_addr same cycle, new slot survives
    set_ins(4, 77, 3, 1); set_fla(4, 3); cyc();
    chk(4, 3, "R10");
    chk_bit(lk_hit, 1'b1, "R10 new entry valid");
    // R7: flush_all with insert discarded
    set_ins(5, 55, 0, 1); flush_all = 1; cyc();
    chk(5, 0, "R7");
    chk(4, 3, "R7");
    set_ins(6, 66, 0, 0); cyc();
    chk(6, 0, "R7");
    chk_bit(lk_idx == 0, 1'b1, "R7 pointer back to 0");
    // random mixed stimulus, R2 R3 R4 R5 R6 R8 R9 R10
    for (int it = 0; it < 4000; it++) begin
      int op;
      op = $urandom % 40;
      if (op < 22) set_ins($urandom % 6, $urandom, $urandom % 3, ($urandom % 4) == 0);
      if (op >= 16 && op < 26) set_fla($urandom % 6, $urandom % 3);
      if (op == 27 || op == 28) flush_proc = 1;
      if (op == 39) flush_all = 1;
      cyc();
      for (int q = 0; q < 3; q++) chk($urandom % 6, $urandom % 3, "R5");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule